// File: doc/BRIEF.md
# Store-to-load forwarding range selector

This block decides which entries of a circular store queue a load has to search when it looks for data to forward from earlier stores. It takes two pointers. One is the queue's dequeue pointer, which marks the oldest live store. The other is the store-queue position recorded with the load. Each pointer is a wrap flag plus an entry index. From these the block builds the set of stores that are older than the load. It splits that set into two entry-select vectors, one bit per queue entry, and ANDs each vector with a per-entry address-match vector supplied from outside.

The first vector covers the entries that carry the same wrap flag as the dequeue pointer. The second covers the segment that has wrapped back to index 0. Within either vector a higher bit index is always a younger store. A later priority stage can therefore pick the youngest match by plain index order, and it gives the second vector precedence over the first. The block can register its two outputs behind an enable, so that the data selection downstream runs one cycle after the query.

The queue depth must be a power of two, no larger than 64. The index width is log2 of the depth. Only legal pointer pairs are defined:
- With equal flags, the load index is at or above the dequeue index.
- With differing flags, the load index is at or below the dequeue index.

Top module: `sq_fwd_range`

## Requirements
- R1: When the two wrap flags are equal, bit j of the first vector is set exactly for tail_idx <= j < load_idx, and the second vector is all zeros.
- R2: When the wrap flags differ, bit j of the first vector is set exactly for tail_idx <= j <= DEPTH-1.
- R3: When the wrap flags differ, bit j of the second vector is set exactly for 0 <= j < load_idx. With load_idx = 0 the vector is all zeros.
- R4: When the flags are equal and the two indices are equal, both vectors are all zeros, because there are no older stores.
- R5: Every output bit j is the range bit j ANDed with addr_hit[j]. An entry whose address does not match never appears in either output.
- R6: With REG_OUT = 1, when cap_en is high at a rising clock edge, both outputs take that edge's gated vectors. When cap_en is low, both outputs hold their previous values, whatever the other inputs do.
- R7: While rst_n is low, both registered outputs are all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| cap_en | input | 1 | Capture enable for the output register |
| tail_flag | input | 1 | Wrap flag of the dequeue pointer |
| tail_idx | input | IDXW | Entry index of the dequeue pointer |
| load_flag | input | 1 | Wrap flag of the load's store-queue position |
| load_idx | input | IDXW | Entry index of the load's store-queue position |
| addr_hit | input | DEPTH | Per-entry address-match vector |
| sel_old | output | DEPTH | Matching older stores that share the tail's wrap flag |
| sel_new | output | DEPTH | Matching older stores in the wrapped segment |

## Verification
The bench builds the block with DEPTH = 8 and REG_OUT = 1. That makes it practical to walk every legal pair of dequeue and load pointers under all four flag combinations. Each pair is applied once with a full address-match vector and once with a pseudo-random one, so both range edges, the empty range and the full-queue case are all reached. The registered output stage is exercised for capture, for holding while the enable is low, and for reset; the unregistered variant is not built by this bench.

// File: rtl/sq_fwd_range_pkg.sv
package sq_fwd_range_pkg;

  localparam int MAX_DEPTH = 64;

  // Bits j with lo <= j < hi set, all others clear.
  function automatic bit [MAX_DEPTH-1:0] span_mask(input int lo, input int hi);
    bit [MAX_DEPTH-1:0] m;
    m = '0;
    for (int j = 0; j < MAX_DEPTH; j++) begin
      m[j] = (j >= lo) && (j < hi);
    end
    return m;
  endfunction

endpackage

// File: rtl/sqr_range_gen.sv
module sqr_range_gen #(
  parameter int DEPTH = 16,
  parameter int IDXW  = $clog2(DEPTH)
) (
  input  logic            tail_flag,
  input  logic [IDXW-1:0] tail_idx,
  input  logic            load_flag,
  input  logic [IDXW-1:0] load_idx,
  output logic            flags_same,
  output logic [DEPTH-1:0] span_old,
  output logic [DEPTH-1:0] span_new
);
  import sq_fwd_range_pkg::*;

  logic [DEPTH-1:0] tail_to_load;
  logic [DEPTH-1:0] tail_to_top;
  logic [DEPTH-1:0] base_to_load;

  assign flags_same   = (tail_flag == load_flag);
  assign tail_to_load = DEPTH'(span_mask(int'(tail_idx), int'(load_idx)));
  assign tail_to_top  = DEPTH'(span_mask(int'(tail_idx), DEPTH));
  assign base_to_load = DEPTH'(span_mask(0, int'(load_idx)));

  always_comb begin
    if (flags_same) begin
      span_old = tail_to_load;
      span_new = '0;
    end else begin
      span_old = tail_to_top;
      span_new = base_to_load;
    end
  end

endmodule

// File: rtl/sqr_hit_gate.sv
module sqr_hit_gate #(
  parameter int DEPTH = 16
) (
  input  logic [DEPTH-1:0] span_old,
  input  logic [DEPTH-1:0] span_new,
  input  logic [DEPTH-1:0] addr_hit,
  output logic [DEPTH-1:0] gated_old,
  output logic [DEPTH-1:0] gated_new
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    assign gated_old[e] = span_old[e] & addr_hit[e];
    assign gated_new[e] = span_new[e] & addr_hit[e];
  end
endmodule

// File: rtl/sqr_out_stage.sv
module sqr_out_stage #(
  parameter int DEPTH   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DEPTH-1:0] d_old,
  input  logic [DEPTH-1:0] d_new,
  output logic [DEPTH-1:0] q_old,
  output logic [DEPTH-1:0] q_new
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_old <= '0;
        q_new <= '0;
      end else if (en) begin
        q_old <= d_old;
        q_new <= d_new;
      end
    end
  end else begin : g_pass
    logic unused_ctl;
    assign unused_ctl = &{1'b0, clk, rst_n, en};
    assign q_old = d_old;
    assign q_new = d_new;
  end
endmodule

// File: rtl/sq_fwd_range.sv
module sq_fwd_range #(
  parameter int DEPTH   = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int IDXW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             tail_flag,
  input  logic [IDXW-1:0]  tail_idx,
  input  logic             load_flag,
  input  logic [IDXW-1:0]  load_idx,
  input  logic [DEPTH-1:0] addr_hit,
  output logic [DEPTH-1:0] sel_old,
  output logic [DEPTH-1:0] sel_new
);
  logic             flags_same;
  logic [DEPTH-1:0] span_old;
  logic [DEPTH-1:0] span_new;
  logic [DEPTH-1:0] gated_old;
  logic [DEPTH-1:0] gated_new;

  sqr_range_gen #(.DEPTH(DEPTH), .IDXW(IDXW)) u_range (
    .tail_flag (tail_flag),
    .tail_idx  (tail_idx),
    .load_flag (load_flag),
    .load_idx  (load_idx),
    .flags_same(flags_same),
    .span_old  (span_old),
    .span_new  (span_new)
  );

  sqr_hit_gate #(.DEPTH(DEPTH)) u_gate (
    .span_old (span_old),
    .span_new (span_new),
    .addr_hit (addr_hit),
    .gated_old(gated_old),
    .gated_new(gated_new)
  );

  sqr_out_stage #(.DEPTH(DEPTH), .REG_OUT(REG_OUT)) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (cap_en),
    .d_old(gated_old),
    .d_new(gated_new),
    .q_old(sel_old),
    .q_new(sel_new)
  );

endmodule

// File: rtl/sq_fwd_range_chk.sv
module sq_fwd_range_chk #(
  parameter int DEPTH   = 16,
  parameter bit REG_OUT = 1'b1,
  parameter int IDXW    = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_en,
  input logic [IDXW-1:0]  tail_idx,
  input logic [IDXW-1:0]  load_idx,
  input logic [DEPTH-1:0] addr_hit,
  input logic             flags_same,
  input logic [DEPTH-1:0] span_old,
  input logic [DEPTH-1:0] span_new,
  input logic [DEPTH-1:0] gated_old,
  input logic [DEPTH-1:0] gated_new,
  input logic [DEPTH-1:0] sel_old,
  input logic [DEPTH-1:0] sel_new
);
  assert_same_flag_new_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flags_same |-> (span_new == '0));

  assert_wrap_old_reaches_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_same) |-> (span_old[DEPTH-1] && span_old[tail_idx]));

  assert_wrap_new_from_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_same && load_idx != '0) |-> span_new[0]);

  assert_empty_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_same && tail_idx == load_idx) |-> (span_old == '0 && span_new == '0));

  assert_gate_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((gated_old & ~addr_hit) == '0) && ((gated_new & ~addr_hit) == '0));

  if (REG_OUT) begin : g_reg_chk
    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> (sel_old == $past(gated_old) && sel_new == $past(gated_new)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_en) |=> ($stable(sel_old) && $stable(sel_new)));

    assert_reset_clear_R7: assert property (@(posedge clk)
      (!rst_n) |-> (sel_old == '0 && sel_new == '0));
  end

endmodule

bind sq_fwd_range sq_fwd_range_chk #(.DEPTH(DEPTH), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cap_en    (cap_en),
  .tail_idx  (tail_idx),
  .load_idx  (load_idx),
  .addr_hit  (addr_hit),
  .flags_same(flags_same),
  .span_old  (span_old),
  .span_new  (span_new),
  .gated_old (gated_old),
  .gated_new (gated_new),
  .sel_old   (sel_old),
  .sel_new   (sel_new)
);

// File: tb/tb_sq_fwd_range.sv
`timescale 1ns/1ps
module tb_sq_fwd_range;
  localparam int D  = 8;
  localparam int IW = $clog2(D);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cap_en = 1'b0;
  logic          tail_flag = 1'b0;
  logic [IW-1:0] tail_idx = '0;
  logic          load_flag = 1'b0;
  logic [IW-1:0] load_idx = '0;
  logic [D-1:0]  addr_hit = '0;
  logic [D-1:0]  sel_old;
  logic [D-1:0]  sel_new;

  sq_fwd_range #(.DEPTH(D), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
    .tail_flag(tail_flag), .tail_idx(tail_idx),
    .load_flag(load_flag), .load_idx(load_idx),
    .addr_hit(addr_hit), .sel_old(sel_old), .sel_new(sel_new)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [D-1:0] e_old;
    logic [D-1:0] e_new;
    string        tag_old;
    string        tag_new;
  } item_t;

  item_t        sb[$];
  int           checks = 0;
  int           errors = 0;
  bit           drv_done = 1'b0;
  logic [D-1:0] last_old = '0;
  logic [D-1:0] last_new = '0;
  logic [15:0]  lfsr = 16'hACE1;

  // Reference: walk from the tail in age order; an entry is older than the
  // load if its distance from the tail is below the load's distance.
  function automatic void ref_masks(input int tf, input int ti, input int lf, input int li,
                                    output logic [D-1:0] o, output logic [D-1:0] n);
    int dl;
    dl = ((lf * D + li) - (tf * D + ti) + 2 * D) % (2 * D);
    o = '0;
    n = '0;
    for (int j = 0; j < D; j++) begin
      int dj;
      dj = (j - ti + D) % D;
      if (dj < dl) begin
        if (j >= ti) o[j] = 1'b1;
        else         n[j] = 1'b1;
      end
    end
  endfunction

  task automatic check_vec(input string tag, input logic [D-1:0] act, input logic [D-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input bit en, input int tf, input int ti, input int lf, input int li,
                       input logic [D-1:0] hit, input string t_old, input string t_new);
    item_t it;
    logic [D-1:0] ro, rn;
    @(negedge clk);
    cap_en    = en;
    tail_flag = tf[0];
    tail_idx  = IW'(ti);
    load_flag = lf[0];
    load_idx  = IW'(li);
    addr_hit  = hit;
    ref_masks(tf, ti, lf, li, ro, rn);
    if (en) begin
      last_old = ro & hit;
      last_new = rn & hit;
    end
    it.e_old   = last_old;
    it.e_new   = last_new;
    it.tag_old = t_old;
    it.tag_new = t_new;
    sb.push_back(it);
  endtask

  // Monitor: one registered result per clock, compared just after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check_vec(it.tag_old, sel_old, it.e_old);
        check_vec(it.tag_new, sel_new, it.e_new);
      end
    end
  end

  // Watchdog
  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R7: outputs stay clear during reset even with capture enabled
    cap_en = 1'b1;
    tail_idx = 3'd1;
    load_flag = 1'b1;
    addr_hit = '1;
    repeat (3) @(posedge clk);
    #1;
    check_vec("R7 reset old", sel_old, '0);
    check_vec("R7 reset new", sel_new, '0);
    @(negedge clk);
    cap_en = 1'b0;
    rst_n  = 1'b1;

    for (int tf = 0; tf < 2; tf++) begin
      for (int lf = 0; lf < 2; lf++) begin
        for (int ti = 0; ti < D; ti++) begin
          for (int li = 0; li < D; li++) begin
            bit legal;
            legal = (tf == lf) ? (li >= ti) : (li <= ti);
            if (legal) begin
              string to, tn;
              if (tf == lf && ti == li) begin
                to = "R4 empty old"; tn = "R4 empty new";
              end else if (tf == lf) begin
                to = "R1 same-flag old"; tn = "R1 same-flag new";
              end else begin
                to = "R2 wrap old"; tn = "R3 wrap new";
              end
              drive(1'b1, tf, ti, lf, li, '1, to, tn);
              lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
              drive(1'b1, tf, ti, lf, li, lfsr[D-1:0], "R5 gated old", "R5 gated new");
            end
          end
        end
      end
    end

    // R6: load a full-queue result, then hold it while inputs change
    drive(1'b1, 1, 4, 0, 4, '1, "R2 full old", "R3 full new");
    drive(1'b0, 0, 0, 0, 0, '1, "R6 hold old", "R6 hold new");
    drive(1'b0, 0, 2, 0, 7, 8'h5A, "R6 hold old", "R6 hold new");
    drive(1'b1, 0, 2, 0, 7, 8'hFF, "R6 capture old", "R6 capture new");
    drive(1'b0, 1, 7, 0, 0, '1, "R6 hold old", "R6 hold new");
    @(negedge clk);
    cap_en = 1'b0;
    repeat (3) @(posedge clk);
    drv_done = 1'b1;
  end

  initial begin
    wait (drv_done);
    #2;
    if (sb.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard left %0d items actual=%0d expected=0", sb.size(), sb.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule